// File: doc/BRIEF.md
# Streaming Max-Log Bit LLR Generator

This block turns the candidate list of a list-based MIMO detector into soft bit decisions. A tree-search front end hands over a list of candidate symbol vectors, several per clock. Each candidate carries a bit label and an unsigned distance metric. For every label bit the block keeps two running minima: one over the candidates whose bit is 0 and one over those whose bit is 1. When the last batch of a list has been absorbed, it emits every bit LLR as the difference of its two minima. A channel decoder downstream takes the LLRs.

Earlier batches are never stored. Each cycle, a comparator tree reduces the incoming batch to per-bit batch minima. These are folded into the running minima at once. The first batch of a list reloads the running state instead of merging into it, so lists can follow each other with no idle cycle. The default build covers four antennas with eight bits each, eight candidates per batch and eight batches per list.

Top module: `llr_stream_gen`

## Requirements
- R1: A batch places candidate c of the cycle at in_labels[c*32 +: 32] (label bit b at position b) and its unsigned 16-bit metric at in_metrics[c*16 +: 16]; a list is 64 candidates in 8 batches of 8.
- R2: Lane b of out_llr, out_llr[b*17 +: 17], is a 17-bit two's complement value equal to the smallest metric among candidates whose label bit b is 1, minus the smallest metric among candidates whose bit b is 0.
- R3: The minima cover every batch of the list, so a minimum that arrived in the first batch is still reflected after the eighth.
- R4: If no candidate of the list has bit b at 1, lane b is +65535; if none has it at 0, lane b is -65535. A genuine metric of 65535 counts as a present candidate and does not saturate.
- R5: out_valid is high for exactly one cycle, the cycle after the clock edge that takes the batch with in_last, and is low at all other times; out_llr keeps its value between pulses.
- R6: A list is exactly 8 valid batches with in_last on the eighth; the next valid cycle, including the one right after, starts a new list that inherits nothing from the previous one.
- R7: Cycles with in_valid low change nothing, whatever the other inputs carry, even in the middle of a list.
- R8: A synchronous active-high reset drops out_valid, sets out_llr to zero and throws away a partly received list, so the next valid batch starts a new list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A batch of candidates is present |
| in_last | input | 1 | The batch is the final one of its list |
| in_labels | input | 256 | Bit labels, 32 per candidate, 8 candidates |
| in_metrics | input | 128 | Unsigned metrics, 16 bits per candidate |
| out_valid | output | 1 | One-cycle strobe: out_llr holds a new list's LLRs |
| out_llr | output | 544 | 32 signed 17-bit LLR lanes |

## Verification
The bench builds the block with its default parameters: 32 label bits, 8 candidates per batch, 8 batches per list and 16-bit metrics. At this width the saturation value 65535 and a real metric of 65535 are both within reach. A batch of eight is enough for metric ties to occur inside one batch and across batches. With the full list length, a minimum can be placed in the first batch or in the last, and a list can start immediately after another one ends.

// File: rtl/llr_gen_pkg.sv
package llr_gen_pkg;

  localparam int DEF_NTX    = 4;
  localparam int DEF_BPS    = 8;
  localparam int DEF_NPB    = 8;
  localparam int DEF_NBATCH = 8;
  localparam int DEF_MW     = 16;

  // Comparator step shared by the batch tree and the running merge.
  // Returns 1 when the right-hand contender should win. Ties keep the
  // left one, which holds the lower index or the earlier batch.
  function automatic logic take_right(input logic        l_ok,
                                      input logic        r_ok,
                                      input logic [31:0] l_val,
                                      input logic [31:0] r_val);
    return r_ok && (!l_ok || (r_val < l_val));
  endfunction

endpackage

// File: rtl/llr_batch_min.sv
module llr_batch_min
  import llr_gen_pkg::*;
#(
  parameter int NBITS = 32,
  parameter int NPB   = 8,
  parameter int MW    = 16
) (
  input  logic [NPB*NBITS-1:0]      labels,
  input  logic [NPB*MW-1:0]         metrics,
  output logic [NBITS-1:0][MW-1:0]  min0,
  output logic [NBITS-1:0][MW-1:0]  min1,
  output logic [NBITS-1:0]          seen0,
  output logic [NBITS-1:0]          seen1
);

  // Heap-ordered balanced tree: nodes 0..NPB-2 compare, leaves follow.
  localparam int NODES = 2 * NPB - 1;
  localparam int LEAF0 = NPB - 1;

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    for (genvar h = 0; h < 2; h++) begin : g_hyp
      logic [MW-1:0] nv  [NODES];
      logic          nok [NODES];

      for (genvar i = 0; i < NPB; i++) begin : g_leaf
        assign nok[LEAF0+i] = (labels[i*NBITS+b] == 1'(h));
        assign nv[LEAF0+i]  = metrics[i*MW +: MW];
      end

      for (genvar k = 0; k < LEAF0; k++) begin : g_node
        logic pick_r;
        assign pick_r = take_right(nok[2*k+1], nok[2*k+2],
                                   32'(nv[2*k+1]), 32'(nv[2*k+2]));
        assign nv[k]  = pick_r ? nv[2*k+2] : nv[2*k+1];
        assign nok[k] = nok[2*k+1] | nok[2*k+2];
      end

      if (h == 0) begin : g_zero
        assign min0[b]  = nv[0];
        assign seen0[b] = nok[0];
      end else begin : g_one
        assign min1[b]  = nv[0];
        assign seen1[b] = nok[0];
      end
    end
  end

endmodule

// File: rtl/llr_accum.sv
module llr_accum
  import llr_gen_pkg::*;
#(
  parameter int NBITS  = 32,
  parameter int NBATCH = 8,
  parameter int MW     = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      in_last,
  input  logic [NBITS-1:0][MW-1:0]  bmin0,
  input  logic [NBITS-1:0][MW-1:0]  bmin1,
  input  logic [NBITS-1:0]          bseen0,
  input  logic [NBITS-1:0]          bseen1,
  output logic [NBITS-1:0][MW-1:0]  nmin0,
  output logic [NBITS-1:0][MW-1:0]  nmin1,
  output logic [NBITS-1:0]          nseen0,
  output logic [NBITS-1:0]          nseen1
);

  localparam int CW = (NBATCH > 1) ? $clog2(NBATCH) : 1;

  logic [NBITS-1:0][MW-1:0] acc0, acc1;
  logic [NBITS-1:0]         aseen0, aseen1;
  logic                     first_q;
  logic [CW-1:0]            cnt;

  // On a list's first batch the stored state is replaced by the
  // all-ones / not-seen starting point before the merge.
  for (genvar b = 0; b < NBITS; b++) begin : g_merge
    logic [MW-1:0] base0, base1;
    logic          bok0, bok1, t0, t1;

    assign base0 = first_q ? {MW{1'b1}} : acc0[b];
    assign base1 = first_q ? {MW{1'b1}} : acc1[b];
    assign bok0  = !first_q && aseen0[b];
    assign bok1  = !first_q && aseen1[b];
    assign t0    = take_right(bok0, bseen0[b], 32'(base0), 32'(bmin0[b]));
    assign t1    = take_right(bok1, bseen1[b], 32'(base1), 32'(bmin1[b]));

    assign nmin0[b]  = t0 ? bmin0[b] : base0;
    assign nmin1[b]  = t1 ? bmin1[b] : base1;
    assign nseen0[b] = bok0 | bseen0[b];
    assign nseen1[b] = bok1 | bseen1[b];

    // R3
    mono0_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !first_q && aseen0[b]) |=> (acc0[b] <= $past(acc0[b])));
    // R3
    mono1_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !first_q && aseen1[b]) |=> (acc1[b] <= $past(acc1[b])));
    // R6
    reload_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && first_q && !bseen0[b]) |=> !aseen0[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b1;
      cnt     <= '0;
      acc0    <= '1;
      acc1    <= '1;
      aseen0  <= '0;
      aseen1  <= '0;
    end else if (in_valid) begin
      first_q <= in_last;
      cnt     <= in_last ? '0 : cnt + CW'(1);
      acc0    <= nmin0;
      acc1    <= nmin1;
      aseen0  <= nseen0;
      aseen1  <= nseen1;
    end
  end

  // R6
  last_batch_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |-> (cnt == CW'(NBATCH - 1)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(acc0) && $stable(acc1) && $stable(first_q) && $stable(cnt)));

endmodule

// File: rtl/llr_out_stage.sv
module llr_out_stage #(
  parameter int NBITS = 32,
  parameter int MW    = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         take,
  input  logic [NBITS-1:0][MW-1:0]     fmin0,
  input  logic [NBITS-1:0][MW-1:0]     fmin1,
  input  logic [NBITS-1:0]             fseen0,
  input  logic [NBITS-1:0]             fseen1,
  output logic                         out_valid,
  output logic [NBITS*(MW+1)-1:0]      out_llr
);

  localparam int LW = MW + 1;
  localparam logic signed [LW-1:0] POS_SAT = {1'b0, {MW{1'b1}}};
  localparam logic signed [LW-1:0] NEG_SAT = -POS_SAT;

  // Max-log difference with saturation for a missing hypothesis.
  function automatic logic signed [LW-1:0] bit_llr(input logic          ok0,
                                                   input logic          ok1,
                                                   input logic [MW-1:0] m0,
                                                   input logic [MW-1:0] m1);
    if (!ok1) return POS_SAT;
    if (!ok0) return NEG_SAT;
    return $signed({1'b0, m1}) - $signed({1'b0, m0});
  endfunction

  logic [NBITS-1:0][LW-1:0] llr_d, llr_q;

  always_comb begin
    for (int b = 0; b < NBITS; b++) begin
      llr_d[b] = bit_llr(fseen0[b], fseen1[b], fmin0[b], fmin1[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      llr_q     <= '0;
    end else begin
      out_valid <= take;
      if (take) llr_q <= llr_d;
    end
  end

  assign out_llr = llr_q;

  // R5
  llr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(llr_q));

endmodule

// File: rtl/llr_stream_gen.sv
module llr_stream_gen
  import llr_gen_pkg::*;
#(
  parameter int NTX    = DEF_NTX,
  parameter int BPS    = DEF_BPS,
  parameter int NPB    = DEF_NPB,
  parameter int NBATCH = DEF_NBATCH,
  parameter int MW     = DEF_MW
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic                              in_last,
  input  logic [NPB*NTX*BPS-1:0]            in_labels,
  input  logic [NPB*MW-1:0]                 in_metrics,
  output logic                              out_valid,
  output logic [NTX*BPS*(MW+1)-1:0]         out_llr
);

  localparam int NBITS = NTX * BPS;

  logic [NBITS-1:0][MW-1:0] bmin0, bmin1, nmin0, nmin1;
  logic [NBITS-1:0]         bseen0, bseen1, nseen0, nseen1;
  logic                     list_done;

  assign list_done = in_valid && in_last;

  llr_batch_min #(.NBITS(NBITS), .NPB(NPB), .MW(MW)) i_batch (
    .labels  (in_labels),
    .metrics (in_metrics),
    .min0    (bmin0),
    .min1    (bmin1),
    .seen0   (bseen0),
    .seen1   (bseen1)
  );

  llr_accum #(.NBITS(NBITS), .NBATCH(NBATCH), .MW(MW)) i_accum (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_last  (in_last),
    .bmin0    (bmin0),
    .bmin1    (bmin1),
    .bseen0   (bseen0),
    .bseen1   (bseen1),
    .nmin0    (nmin0),
    .nmin1    (nmin1),
    .nseen0   (nseen0),
    .nseen1   (nseen1)
  );

  llr_out_stage #(.NBITS(NBITS), .MW(MW)) i_out (
    .clk       (clk),
    .rst       (rst),
    .take      (list_done),
    .fmin0     (nmin0),
    .fmin1     (nmin1),
    .fseen0    (nseen0),
    .fseen1    (nseen1),
    .out_valid (out_valid),
    .out_llr   (out_llr)
  );

  // R5
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    list_done |=> out_valid);
  // R5
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !list_done |=> !out_valid);

endmodule

// File: tb/test_llr_stream_gen.sv
module test_llr_stream_gen;

  localparam int NBITS = 32;
  localparam int NPB   = 8;
  localparam int NB    = 8;
  localparam int NC    = NPB * NB;
  localparam int MW    = 16;
  localparam int LW    = MW + 1;
  localparam int OW    = NBITS * LW;

  typedef struct packed {
    logic [31:0] seed;
    logic [31:0] and_m;
    logic [31:0] or_m;
    logic [15:0] met_or;
    logic [1:0]  kind;   // 0 random, 1 rising, 2 falling, 3 narrow (ties)
    logic        gap;    // idle cycle between batches
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'd1, 32'hffffffff, 32'h00000000, 16'h0000, 2'd0, 1'b0},
    '{32'd2, 32'hffffffff, 32'h00000000, 16'h0000, 2'd0, 1'b1},
    '{32'd3, 32'hfffffff0, 32'h00000000, 16'h0000, 2'd0, 1'b0},
    '{32'd4, 32'hffffffff, 32'h0000ff00, 16'h0000, 2'd0, 1'b0},
    '{32'd5, 32'h00000000, 32'h00000000, 16'h0000, 2'd0, 1'b0},
    '{32'd6, 32'hffffffff, 32'h00000000, 16'hffff, 2'd0, 1'b0},
    '{32'd7, 32'hffffffff, 32'h00000000, 16'h0000, 2'd1, 1'b0},
    '{32'd8, 32'hffffffff, 32'h00000000, 16'h0000, 2'd2, 1'b0},
    '{32'd9, 32'hffffffff, 32'h00000000, 16'h0000, 2'd3, 1'b1}
  };

  logic clk = 1'b0;
  logic rst, in_valid, in_last;
  logic [NPB*NBITS-1:0] in_labels;
  logic [NPB*MW-1:0]    in_metrics;
  logic                 out_valid;
  logic [OW-1:0]        out_llr;

  int n_checks = 0;
  int n_fails  = 0;

  logic [31:0] lab [NC];
  logic [15:0] met [NC];
  logic [OW-1:0] cur_exp, pend_vec, last_vec;
  logic pending  = 1'b0;
  logic have_last = 1'b0;
  string cur_tag, pend_tag;

  always #5 clk = ~clk;

  llr_stream_gen i_llr_stream_gen (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_labels  (in_labels),
    .in_metrics (in_metrics),
    .out_valid  (out_valid),
    .out_llr    (out_llr)
  );

  function automatic logic [31:0] mix(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic string tag_of(input vec_t v);
    if (v.gap) return "R7";
    if (v.and_m != 32'hffffffff || v.or_m != 0 || v.met_or != 0) return "R4";
    if (v.kind == 2'd1 || v.kind == 2'd2) return "R3";
    return "R2";
  endfunction

  task automatic gen_list(input vec_t v);
    for (int c = 0; c < NC; c++) begin
      logic [31:0] r, r2;
      r  = mix(mix(v.seed * 32'h9E3779B9) ^ ((c + 1) * 32'h85EBCA6B));
      r2 = mix(r ^ 32'h27D4EB2D);
      lab[c] = (r & v.and_m) | v.or_m;
      case (v.kind)
        2'd1:    met[c] = 16'(200 + c * 37) + 16'(r2[2:0]);
        2'd2:    met[c] = 16'(200 + (NC - 1 - c) * 37) + 16'(r2[2:0]);
        2'd3:    met[c] = 16'(r2[3:0]);
        default: met[c] = r2[15:0] | v.met_or;
      endcase
    end
  endtask

  // Reference: scan the whole list per bit, both hypotheses.
  task automatic calc_expected(output logic [OW-1:0] e);
    for (int b = 0; b < NBITS; b++) begin
      logic f0, f1;
      logic [15:0] m0, m1;
      logic signed [LW-1:0] d;
      f0 = 1'b0; f1 = 1'b0; m0 = '0; m1 = '0;
      for (int c = 0; c < NC; c++) begin
        if (lab[c][b]) begin
          if (!f1 || met[c] < m1) m1 = met[c];
          f1 = 1'b1;
        end else begin
          if (!f0 || met[c] < m0) m0 = met[c];
          f0 = 1'b1;
        end
      end
      if (!f1)      d = 17'sd65535;
      else if (!f0) d = -17'sd65535;
      else          d = $signed({1'b0, m1}) - $signed({1'b0, m0});
      e[b*LW +: LW] = d;
    end
  endtask

  // One cycle: check what the last edge produced, then drive new inputs.
  task automatic tick(input logic v, input logic l,
                      input logic [NPB*NBITS-1:0] labs,
                      input logic [NPB*MW-1:0] mets);
    @(negedge clk);
    n_checks++;
    if (pending) begin
      // R1 R6: back-to-back lists and field layout feed this comparison
      if (out_valid !== 1'b1 || out_llr !== pend_vec) begin
        n_fails++;
        $display("FAIL %s (R1 R5 R6): out_valid=%b out_llr=%h expected out_valid=1 out_llr=%h",
                 pend_tag, out_valid, out_llr, pend_vec);
      end
      last_vec  = pend_vec;
      have_last = 1'b1;
    end else if (out_valid !== 1'b0 || (have_last && out_llr !== last_vec)) begin
      n_fails++;
      $display("FAIL R5: out_valid=%b out_llr=%h expected out_valid=0 out_llr=%h",
               out_valid, out_llr, last_vec);
    end
    pending    = 1'b0;
    in_valid   = v;
    in_last    = l;
    in_labels  = labs;
    in_metrics = mets;
    if (v && l) begin
      pending  = 1'b1;
      pend_vec = cur_exp;
      pend_tag = cur_tag;
    end
  endtask

  task automatic idle_tick();
    // Junk with valid low: zero metrics would win every minimum if taken (R7)
    tick(1'b0, 1'b1, {NPB{32'h5a5a_a5a5}}, '0);
  endtask

  task automatic send_batches(input int n, input logic gap);
    for (int bt = 0; bt < n; bt++) begin
      logic [NPB*NBITS-1:0] labs;
      logic [NPB*MW-1:0]    mets;
      for (int c = 0; c < NPB; c++) begin
        labs[c*NBITS +: NBITS] = lab[bt*NPB + c];
        mets[c*MW +: MW]       = met[bt*NPB + c];
      end
      tick(1'b1, bt == NB - 1, labs, mets);
      if (gap && bt < NB - 1) idle_tick();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst      = 1'b1;
    in_valid = 1'b0;
    in_last  = 1'b0;
    pending  = 1'b0;
    @(negedge clk);
    n_checks++;
    // R8: reset state
    if (out_valid !== 1'b0 || out_llr !== '0) begin
      n_fails++;
      $display("FAIL R8: out_valid=%b out_llr=%h expected out_valid=0 out_llr=0",
               out_valid, out_llr);
    end
    rst       = 1'b0;
    last_vec  = '0;
    have_last = 1'b1;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0;
    in_labels = '0; in_metrics = '0;
    repeat (2) @(posedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      gen_list(v);
      calc_expected(cur_exp);
      cur_tag = tag_of(v);
      send_batches(NB, v.gap);
    end
    repeat (3) idle_tick();

    // R8: abandon half a list with a reset, then send a fresh list
    gen_list('{32'd77, 32'hffffffff, 32'h0, 16'h0, 2'd3, 1'b0});
    send_batches(NB / 2, 1'b0);
    do_reset();
    gen_list('{32'd78, 32'hffffffff, 32'h0, 16'h0, 2'd0, 1'b0});
    calc_expected(cur_exp);
    cur_tag = "R8";
    send_batches(NB, 1'b0);
    repeat (3) idle_tick();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R5 watchdog: run still active after 20000 cycles, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule